// File: doc/BRIEF.md
# Multithreaded Windowed Integer Register File

This block holds the integer registers of many hardware threads in one shared RAM. Each thread owns a 64-entry slice of that RAM. The slice holds eight global registers and three rotating windows of sixteen registers each. A 5-bit architectural register number, the thread number and that thread's current window pointer (CWP) are turned into a physical address. The address is the thread number placed above a 6-bit index within the slice. Entries 56 to 63 of each slice are never addressed by the register mapping. They are left free for per-thread trap state.

The block has three ports on the RAM. A read request carries one thread and two source registers, and its data returns two cycles later. The write port writes one register per cycle. A window port performs SAVE (CWP decrements modulo 3) and RESTORE (CWP increments modulo 3) for one thread at a time. Each thread has a window-invalid mask. If the mask bit of the window that a SAVE or RESTORE would enter is set, the pointer stays where it is and an overflow or underflow flag is raised for one cycle. Handling that trap is left to the surrounding pipeline.

Top module: `mtw_regfile`

## Requirements
- R1: After a synchronous active-low reset, every thread has CWP 0 and a clear window mask. `win_ovf`, `win_unf` and `rd_valid` are 0.
- R2: Registers 1 to 7 are globals. Each thread has its own copy, and that copy is the same in every window of the thread.
- R3: Register 0 always reads as zero. A write to register 0 has no effect.
- R4: Registers 8 to 15 (outs) of window w are the same storage as registers 24 to 31 (ins) of window (w-1) mod 3. Registers 16 to 23 (locals) belong to a single window only.
- R5: When its target window is not masked, SAVE sets CWP to (CWP-1) mod 3 and RESTORE sets CWP to (CWP+1) mod 3. The new value appears on `win_cwp` one cycle later. `win_op` is 0 for SAVE and 1 for RESTORE.
- R6: A SAVE whose target window w has bit w of the thread's mask set pulses `win_ovf` high in the next cycle and leaves CWP unchanged.
- R7: A RESTORE whose target window has its mask bit set pulses `win_unf` high in the next cycle and leaves CWP unchanged.
- R8: A read request accepted in cycle t makes `rd_valid` high, with both data outputs valid, in cycle t+2 only.
- R9: A write to the same register in the same cycle as a read request is not seen by that read, which returns the old value. A read requested in the next cycle sees the new value.
- R10: Reads and writes use the thread's CWP as it stands in the cycle of the request. A window operation in that same cycle affects only later requests.
- R11: A mask write takes effect for window operations from the next cycle on. A window operation in the same cycle as the mask write is checked against the old mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_tid | input | TID_W | Thread of the read request |
| rd_rs1 | input | 5 | First source register number |
| rd_rs2 | input | 5 | Second source register number |
| rd_valid | output | 1 | Read data valid (two cycles after the request) |
| rd_data1 | output | XLEN | Value of the first source register |
| rd_data2 | output | XLEN | Value of the second source register |
| wr_en | input | 1 | Write enable |
| wr_tid | input | TID_W | Thread of the write |
| wr_rd | input | 5 | Destination register number |
| wr_data | input | XLEN | Write data |
| win_en | input | 1 | Window operation request |
| win_op | input | 1 | 0 = SAVE, 1 = RESTORE |
| win_tid | input | TID_W | Thread for the window operation and for `win_cwp` |
| win_cwp | output | CWP_W | Current CWP of thread `win_tid` |
| win_ovf | output | 1 | Window overflow pulse |
| win_unf | output | 1 | Window underflow pulse |
| wim_we | input | 1 | Window mask write enable |
| wim_tid | input | TID_W | Thread whose mask is written |
| wim_val | input | NWIN | New mask; bit w marks window w invalid |

## Verification
Read data and `rd_valid` are due in the second cycle after a request. Window results (`win_ovf`, `win_unf` and the updated `win_cwp`) are due in the first cycle after the operation. The bench drives every input on a falling edge. It samples window results on the next falling edge and read results two falling edges after the request, and it also checks that `rd_valid` is low in the cycle between. The tests for overlapping requests (a write with a read, a window operation with a write, a mask write with a window operation) put both requests in the same cycle. A later read then shows which view of the state each request used.

// File: rtl/mtw_rf_pkg.sv
// Shared constants for the windowed register file.
package mtw_rf_pkg;
    localparam int LOCAL_W    = 6;   // index width inside one thread slice
    localparam int GLOBAL_CNT = 8;   // globals at slice entries 0..7
    localparam int WIN_SIZE   = 16;  // locals then ins per window
    localparam int HALF_WIN   = 8;
    localparam logic OP_SAVE    = 1'b0;
    localparam logic OP_RESTORE = 1'b1;
endpackage

// File: rtl/mtw_rf_addr_map.sv
// Translates (thread, CWP, architectural register) into a physical RAM address.
// Assumes cwp < NWIN and that 8 + 16*NWIN fits in one 64-entry slice.
// Slice layout: globals 0..7, window w locals at 8+16w, ins at 16+16w.
module mtw_rf_addr_map
    import mtw_rf_pkg::*;
#(
    parameter int NWIN  = 3,
    parameter int TID_W = 3,
    parameter int CWP_W = 2
) (
    input  logic [TID_W-1:0]         tid,
    input  logic [CWP_W-1:0]         cwp,
    input  logic [4:0]               areg,
    output logic [TID_W+LOCAL_W-1:0] paddr,
    output logic                     is_zero
);
    int unsigned win_prev;
    int unsigned slot;
    int unsigned idx;

    // Pick the window that owns the register, then the slot inside it.
    always_comb begin
        win_prev = (cwp == '0) ? NWIN - 1 : int'(cwp) - 1;
        slot     = int'(areg[2:0]);
        case (areg[4:3])
            2'd0:    idx = slot;
            2'd1:    idx = GLOBAL_CNT + WIN_SIZE * win_prev + HALF_WIN + slot;
            2'd2:    idx = GLOBAL_CNT + WIN_SIZE * int'(cwp) + slot;
            default: idx = GLOBAL_CNT + WIN_SIZE * int'(cwp) + HALF_WIN + slot;
        endcase
        paddr   = {tid, LOCAL_W'(idx)};
        is_zero = (areg == 5'd0);
    end
endmodule

// File: rtl/mtw_rf_window_ctl.sv
// Per-thread window pointer and window-invalid mask.
// Performs SAVE and RESTORE and raises one-cycle overflow and underflow flags.
// Assumes at most one window operation and one mask write per cycle.
module mtw_rf_window_ctl
    import mtw_rf_pkg::*;
#(
    parameter int NTHREADS = 8,
    parameter int NWIN     = 3,
    parameter int TID_W    = 3,
    parameter int CWP_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      win_en,
    input  logic                      win_op,
    input  logic [TID_W-1:0]          win_tid,
    input  logic                      wim_we,
    input  logic [TID_W-1:0]          wim_tid,
    input  logic [NWIN-1:0]           wim_val,
    output logic [NTHREADS*CWP_W-1:0] cwp_flat,
    output logic                      win_ovf,
    output logic                      win_unf
);
    logic [CWP_W-1:0] cwp_q [NTHREADS];
    logic [NWIN-1:0]  wim_q [NTHREADS];
    logic [CWP_W-1:0] cur;
    logic [CWP_W-1:0] tgt;
    logic             blocked;

    // Target window of the requested operation and whether the mask forbids it.
    always_comb begin
        cur = cwp_q[win_tid];
        if (win_op == OP_SAVE)
            tgt = (cur == '0) ? CWP_W'(NWIN - 1) : cur - 1'b1;
        else
            tgt = (cur == CWP_W'(NWIN - 1)) ? '0 : cur + 1'b1;
        blocked = wim_q[win_tid][tgt];
    end

    // Update the window pointers, the masks and the trap flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NTHREADS; t++) begin
                cwp_q[t] <= '0;
                wim_q[t] <= '0;
            end
            win_ovf <= 1'b0;
            win_unf <= 1'b0;
        end else begin
            if (win_en && !blocked)
                cwp_q[win_tid] <= tgt;
            if (wim_we)
                wim_q[wim_tid] <= wim_val;
            win_ovf <= win_en && blocked && (win_op == OP_SAVE);
            win_unf <= win_en && blocked && (win_op == OP_RESTORE);
        end
    end

    genvar g;
    generate
        for (g = 0; g < NTHREADS; g++) begin : g_cwp_out
            assign cwp_flat[g*CWP_W +: CWP_W] = cwp_q[g];
        end
    endgenerate

    AST_OVF_FROM_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf |-> $past(win_en && win_op == OP_SAVE)); // R6
    AST_UNF_FROM_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        win_unf |-> $past(win_en && win_op == OP_RESTORE)); // R7
    AST_TRAP_KEEPS_CWP: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && blocked) |=> cwp_q[$past(win_tid)] == $past(cur)); // R6
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_ovf && win_unf)); // R7
    AST_CWP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cwp_q[win_tid] < CWP_W'(NWIN)); // R5
endmodule

// File: rtl/mtw_rf_storage.sv
// Shared register RAM with two pipelined read ports and one write port.
// The RAM is read at the first clock edge after a request, and the outputs are
// registered at the second edge. A write at the same edge as the RAM read is
// therefore not seen. The RAM has no reset.
module mtw_rf_storage #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [AW-1:0]   ra_addr,
    input  logic [AW-1:0]   rb_addr,
    input  logic            ra_zero,
    input  logic            rb_zero,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd,
    output logic            rd_valid,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b
);
    logic [XLEN-1:0] mem [DEPTH];
    logic [XLEN-1:0] s1_a, s1_b;
    logic            s1_za, s1_zb;
    logic            s1_valid;

    // Write port.
    always_ff @(posedge clk) begin
        if (we)
            mem[wa] <= wd;
    end

    // First read stage: RAM access.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            s1_a  <= mem[ra_addr];
            s1_b  <= mem[rb_addr];
            s1_za <= ra_zero;
            s1_zb <= rb_zero;
        end
    end

    // Second read stage: force register 0 to zero and register the outputs.
    always_ff @(posedge clk) begin
        if (s1_valid) begin
            rd_a <= s1_za ? '0 : s1_a;
            rd_b <= s1_zb ? '0 : s1_b;
        end
    end

    // Valid pipeline that tracks the read requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            s1_valid <= rd_en;
            rd_valid <= s1_valid;
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ##2 rd_valid); // R8
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(rd_en, 2)); // R8
endmodule

// File: rtl/mtw_regfile.sv
// Top level of the multithreaded windowed register file.
// Three address translators (two read, one write) use the CWP that each
// thread has in the cycle of the request. They feed a shared RAM of
// NTHREADS 64-entry slices. Writes to register 0 are dropped.
module mtw_regfile
    import mtw_rf_pkg::*;
#(
    parameter int NTHREADS = 8,
    parameter int XLEN     = 32,
    parameter int NWIN     = 3,
    localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
    localparam int CWP_W   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [TID_W-1:0] rd_tid,
    input  logic [4:0]       rd_rs1,
    input  logic [4:0]       rd_rs2,
    output logic             rd_valid,
    output logic [XLEN-1:0]  rd_data1,
    output logic [XLEN-1:0]  rd_data2,
    input  logic             wr_en,
    input  logic [TID_W-1:0] wr_tid,
    input  logic [4:0]       wr_rd,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             win_en,
    input  logic             win_op,
    input  logic [TID_W-1:0] win_tid,
    output logic [CWP_W-1:0] win_cwp,
    output logic             win_ovf,
    output logic             win_unf,
    input  logic             wim_we,
    input  logic [TID_W-1:0] wim_tid,
    input  logic [NWIN-1:0]  wim_val
);
    localparam int AW    = TID_W + LOCAL_W;
    localparam int DEPTH = NTHREADS << LOCAL_W;
    localparam int NPORT = 3;  // port 0/1 read, port 2 write

    logic [NTHREADS*CWP_W-1:0] cwp_flat;
    logic [CWP_W-1:0]          cwp_arr  [NTHREADS];
    logic [TID_W-1:0]          map_tid  [NPORT];
    logic [4:0]                map_reg  [NPORT];
    logic [CWP_W-1:0]          map_cwp  [NPORT];
    logic [AW-1:0]             map_addr [NPORT];
    logic                      map_zero [NPORT];
    logic                      mem_we;

    mtw_rf_window_ctl #(
        .NTHREADS (NTHREADS),
        .NWIN     (NWIN),
        .TID_W    (TID_W),
        .CWP_W    (CWP_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_en   (win_en),
        .win_op   (win_op),
        .win_tid  (win_tid),
        .wim_we   (wim_we),
        .wim_tid  (wim_tid),
        .wim_val  (wim_val),
        .cwp_flat (cwp_flat),
        .win_ovf  (win_ovf),
        .win_unf  (win_unf)
    );

    genvar g;
    generate
        for (g = 0; g < NTHREADS; g++) begin : g_cwp_unpack
            assign cwp_arr[g] = cwp_flat[g*CWP_W +: CWP_W];
        end
    endgenerate

    // Route the thread and register of each port into its translator.
    always_comb begin
        map_tid[0] = rd_tid;  map_reg[0] = rd_rs1;
        map_tid[1] = rd_tid;  map_reg[1] = rd_rs2;
        map_tid[2] = wr_tid;  map_reg[2] = wr_rd;
        for (int p = 0; p < NPORT; p++)
            map_cwp[p] = cwp_arr[map_tid[p]];
    end

    generate
        for (g = 0; g < NPORT; g++) begin : g_map
            mtw_rf_addr_map #(
                .NWIN  (NWIN),
                .TID_W (TID_W),
                .CWP_W (CWP_W)
            ) u_map (
                .tid     (map_tid[g]),
                .cwp     (map_cwp[g]),
                .areg    (map_reg[g]),
                .paddr   (map_addr[g]),
                .is_zero (map_zero[g])
            );
        end
    endgenerate

    assign mem_we  = wr_en && !map_zero[2];
    assign win_cwp = cwp_arr[win_tid];

    mtw_rf_storage #(
        .XLEN  (XLEN),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .ra_addr  (map_addr[0]),
        .rb_addr  (map_addr[1]),
        .ra_zero  (map_zero[0]),
        .rb_zero  (map_zero[1]),
        .we       (mem_we),
        .wa       (map_addr[2]),
        .wd       (wr_data),
        .rd_valid (rd_valid),
        .rd_a     (rd_data1),
        .rd_b     (rd_data2)
    );

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_rs1 == 5'd0, 2)) |-> rd_data1 == '0); // R3
    AST_WRITE_IN_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> map_addr[2][AW-1:LOCAL_W] == wr_tid); // R2
    AST_WRITE_IN_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> map_addr[2][LOCAL_W-1:0] < LOCAL_W'(GLOBAL_CNT + WIN_SIZE * NWIN)); // R4
endmodule

// File: tb/sim_mtw_regfile.sv
// Directed bench for mtw_regfile. Inputs change on falling edges, and
// results are sampled on falling edges.
module sim_mtw_regfile;
    localparam int CLK_PERIOD = 10;
    localparam logic SAVE = 1'b0;
    localparam logic RESTORE = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_tid = '0;
    logic [4:0]  rd_rs1 = '0, rd_rs2 = '0;
    logic        rd_valid;
    logic [31:0] rd_data1, rd_data2;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_tid = '0;
    logic [4:0]  wr_rd = '0;
    logic [31:0] wr_data = '0;
    logic        win_en = 1'b0;
    logic        win_op = 1'b0;
    logic [2:0]  win_tid = '0;
    logic [1:0]  win_cwp;
    logic        win_ovf, win_unf;
    logic        wim_we = 1'b0;
    logic [2:0]  wim_tid = '0;
    logic [2:0]  wim_val = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] d1, d2;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtw_regfile u0 (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] t, input logic [4:0] r, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_tid = t; wr_rd = r; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Request at one falling edge; data is sampled two falling edges later.
    task automatic do_read(input logic [2:0] t, input logic [4:0] a, input logic [4:0] b,
                           output logic [31:0] va, output logic [31:0] vb);
        @(negedge clk);
        rd_en = 1'b1; rd_tid = t; rd_rs1 = a; rd_rs2 = b;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk("R8", "rd_valid with data", 32'(rd_valid), 32'd1);
        va = rd_data1; vb = rd_data2;
    endtask

    // Window operation; results are sampled one falling edge later.
    task automatic do_win(input logic [2:0] t, input logic op);
        @(negedge clk);
        win_en = 1'b1; win_tid = t; win_op = op;
        @(negedge clk);
        win_en = 1'b0;
    endtask

    task automatic do_wim(input logic [2:0] t, input logic [2:0] m);
        @(negedge clk);
        wim_we = 1'b1; wim_tid = t; wim_val = m;
        @(negedge clk);
        wim_we = 1'b0;
    endtask

    task automatic t_reset();
        for (int t = 0; t < 8; t++) begin
            win_tid = 3'(t);
            #1 chk("R1", "cwp after reset", 32'(win_cwp), 32'd0);
        end
        chk("R1", "ovf after reset", 32'(win_ovf), 32'd0);
        chk("R1", "unf after reset", 32'(win_unf), 32'd0);
        chk("R1", "rd_valid after reset", 32'(rd_valid), 32'd0);
        // clear mask: a SAVE from window 0 into window 2 must pass
        do_win(3'd7, SAVE);
        chk("R1", "mask clear after reset", 32'(win_ovf), 32'd0);
        do_win(3'd7, RESTORE);
    endtask

    task automatic t_globals();
        do_write(3'd0, 5'd1, 32'h1111_0001);
        do_write(3'd0, 5'd7, 32'h1111_0007);
        do_write(3'd1, 5'd1, 32'h2222_0001);
        do_read(3'd0, 5'd1, 5'd7, d1, d2);
        chk("R2", "t0 g1", d1, 32'h1111_0001);
        chk("R2", "t0 g7", d2, 32'h1111_0007);
        do_read(3'd1, 5'd1, 5'd1, d1, d2);
        chk("R2", "t1 g1 separate", d1, 32'h2222_0001);
        do_win(3'd0, SAVE);
        do_read(3'd0, 5'd1, 5'd7, d1, d2);
        chk("R2", "g1 same in new window", d1, 32'h1111_0001);
        chk("R2", "g7 same in new window", d2, 32'h1111_0007);
        do_win(3'd0, RESTORE);
    endtask

    task automatic t_zero();
        do_write(3'd0, 5'd0, 32'hDEAD_BEEF);
        do_read(3'd0, 5'd0, 5'd0, d1, d2);
        chk("R3", "r0 port1", d1, 32'h0);
        chk("R3", "r0 port2", d2, 32'h0);
        do_read(3'd0, 5'd1, 5'd0, d1, d2);
        chk("R3", "g1 intact after r0 write", d1, 32'h1111_0001);
    endtask

    task automatic t_overlap();
        do_write(3'd2, 5'd8, 32'hAAAA_0008);   // out 0 of window 0
        do_write(3'd2, 5'd16, 32'hCCCC_0000);  // local 0 of window 0
        do_win(3'd2, SAVE);                    // now window 2
        do_read(3'd2, 5'd24, 5'd24, d1, d2);
        chk("R4", "in0 of callee = caller out0", d1, 32'hAAAA_0008);
        do_write(3'd2, 5'd16, 32'hCCCC_0002);  // local 0 of window 2
        do_write(3'd2, 5'd31, 32'hBBBB_001F);  // in7 of window 2
        do_win(3'd2, RESTORE);                 // back to window 0
        do_read(3'd2, 5'd16, 5'd15, d1, d2);
        chk("R4", "local private to window", d1, 32'hCCCC_0000);
        chk("R4", "out7 sees callee in7", d2, 32'hBBBB_001F);
    endtask

    task automatic t_rotate();
        do_win(3'd3, SAVE);
        chk("R5", "save 0->2", 32'(win_cwp), 32'd2);
        do_win(3'd3, SAVE);
        chk("R5", "save 2->1", 32'(win_cwp), 32'd1);
        do_win(3'd3, SAVE);
        chk("R5", "save 1->0", 32'(win_cwp), 32'd0);
        do_win(3'd3, RESTORE);
        chk("R5", "restore 0->1", 32'(win_cwp), 32'd1);
        do_win(3'd3, RESTORE);
        do_win(3'd3, RESTORE);
        chk("R5", "restore 2->0 wraps", 32'(win_cwp), 32'd0);
    endtask

    task automatic t_traps();
        do_wim(3'd4, 3'b100);
        do_win(3'd4, SAVE);
        chk("R6", "overflow flag", 32'(win_ovf), 32'd1);
        chk("R6", "no underflow", 32'(win_unf), 32'd0);
        chk("R6", "cwp held", 32'(win_cwp), 32'd0);
        @(negedge clk);
        chk("R6", "overflow is one pulse", 32'(win_ovf), 32'd0);
        do_wim(3'd4, 3'b010);
        do_win(3'd4, RESTORE);
        chk("R7", "underflow flag", 32'(win_unf), 32'd1);
        chk("R7", "no overflow", 32'(win_ovf), 32'd0);
        chk("R7", "cwp held", 32'(win_cwp), 32'd0);
        do_win(3'd4, SAVE);
        chk("R7", "unmasked save passes", 32'(win_cwp), 32'd2);
    endtask

    task automatic t_wim_timing();
        @(negedge clk);
        wim_we = 1'b1; wim_tid = 3'd5; wim_val = 3'b100;
        win_en = 1'b1; win_tid = 3'd5; win_op = SAVE;
        @(negedge clk);
        wim_we = 1'b0; win_en = 1'b0;
        chk("R11", "same-cycle mask not applied", 32'(win_ovf), 32'd0);
        chk("R11", "save to 2 done", 32'(win_cwp), 32'd2);
        do_win(3'd5, RESTORE);
        do_win(3'd5, SAVE);
        chk("R11", "new mask applied later", 32'(win_ovf), 32'd1);
    endtask

    task automatic t_latency();
        do_write(3'd6, 5'd2, 32'h0606_0002);
        @(negedge clk);
        rd_en = 1'b1; rd_tid = 3'd6; rd_rs1 = 5'd2; rd_rs2 = 5'd0;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R8", "not valid after one cycle", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk("R8", "valid after two cycles", 32'(rd_valid), 32'd1);
        chk("R8", "data after two cycles", rd_data1, 32'h0606_0002);
        @(negedge clk);
        chk("R8", "valid drops", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_collision();
        do_write(3'd6, 5'd17, 32'h0000_0A0A);
        @(negedge clk);
        rd_en = 1'b1; rd_tid = 3'd6; rd_rs1 = 5'd17; rd_rs2 = 5'd17;
        wr_en = 1'b1; wr_tid = 3'd6; wr_rd = 5'd17; wr_data = 32'h0000_0B0B;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        chk("R9", "same-cycle read sees old", rd_data1, 32'h0000_0A0A);
        do_read(3'd6, 5'd17, 5'd17, d1, d2);
        chk("R9", "next read sees new", d2, 32'h0000_0B0B);
    endtask

    task automatic t_cwp_timing();
        // thread 7 at window 0: write a local in the same cycle as SAVE
        @(negedge clk);
        wr_en = 1'b1; wr_tid = 3'd7; wr_rd = 5'd18; wr_data = 32'h7777_0000;
        win_en = 1'b1; win_tid = 3'd7; win_op = SAVE;
        @(negedge clk);
        wr_en = 1'b0; win_en = 1'b0;
        chk("R10", "save done", 32'(win_cwp), 32'd2);
        do_write(3'd7, 5'd18, 32'h7777_0002);
        // read in same cycle as RESTORE uses window 2
        @(negedge clk);
        rd_en = 1'b1; rd_tid = 3'd7; rd_rs1 = 5'd18; rd_rs2 = 5'd18;
        win_en = 1'b1; win_op = RESTORE;
        @(negedge clk);
        rd_en = 1'b0; win_en = 1'b0;
        @(negedge clk);
        chk("R10", "read uses old cwp", rd_data1, 32'h7777_0002);
        do_read(3'd7, 5'd18, 5'd18, d1, d2);
        chk("R10", "write used old cwp", d1, 32'h7777_0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL all requirements: watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_globals();
        t_zero();
        t_overlap();
        t_rotate();
        t_traps();
        t_wim_timing();
        t_latency();
        t_collision();
        t_cwp_timing();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule